// File: doc/BRIEF.md
# Snooped Shared-Memory Access Gate

This block watches the address phase of every memory-bus operation. Part of physical memory is set aside as a window that holds local copies of global shared memory. An access that falls inside this window is checked against a two-bit access state kept for each cache line. The check returns one of three outcomes. The access may proceed against local memory. It may proceed while a notice is also sent to the service processor. Or it may be sent back for a bus retry while the request is passed to the service processor. Accesses outside the window are never held up.

Space in the window is handed out a page at a time, and protection is tracked one cache line at a time. Only the service processor can change a line state. It can write one line, or write the same state into every line of a page in a single operation. The snooping path only reads the states. Forwarded requests wait in a small queue until the service processor takes them. An illegal access is bounced on every attempt until the service processor repairs the line state, so the processor simply keeps retrying.

Top module: `sc_snoop_gate`

## Requirements
- R1: An access whose byte address lies below `WIN_BASE` or at or above `WIN_BASE + PAGE_LINES*NUM_PAGES*LINE_BYTES` always gets action 2'b00 (proceed) and never adds a queue entry.
- R2: Inside the window, a read (op 2'b00) of a line in state 2'b01 (read-only) or 2'b10 (read-write) gets action 2'b00 (proceed).
- R3: Inside the window, a write (op 2'b01) to a read-write line proceeds (2'b00), and a write to a read-only line gets 2'b10 (retry and forward). Op code 2'b11 is treated as a write.
- R4: Inside the window, any operation on a line in state 2'b00 (invalid) gets 2'b10 (retry and forward). State 2'b11 behaves as invalid.
- R5: Inside the window, a cast-out (op 2'b10) of a read-write line gets 2'b01 (proceed and forward). A cast-out of a read-only line gets 2'b10.
- R6: `resp_valid` is high for exactly the one cycle after the cycle in which `bus_valid` was sampled high, and `resp_act` never shows 2'b11 while `resp_valid` is high.
- R7: Every access that is given action 2'b01 or 2'b10 and is queued appears at the queue head in arrival order. The head shows the line-aligned address on `fwd_addr` and the operation on `fwd_op`. It stays stable while `fwd_ready` is low and is removed in a cycle where `fwd_valid` and `fwd_ready` are both high.
- R8: While the queue holds `FWD_DEPTH` entries, every access inside the window gets 2'b10 whatever its line state, and nothing is queued.
- R9: An access that would be forwarded, and whose line address matches a pending queue entry, gets its normal action but is not queued a second time.
- R10: A service-processor line write (`sp_wr_en` with `sp_wr_page` low) sets the state of line `sp_wr_line`. Snooped accesses never change any line state, so an illegal access is retried every time it is issued until such a write repairs the line.
- R11: A page write (`sp_wr_en` with `sp_wr_page` high) sets every line whose index shares the page bits (the upper bits above log2(`PAGE_LINES`)) with `sp_wr_line`, and no other line.
- R12: After reset every line is invalid, the queue is empty and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Address phase present this cycle |
| bus_op | input | 2 | Operation: 00 read, 01 write, 10 cast-out, 11 treated as write |
| bus_addr | input | ADDR_W | Byte address of the operation |
| resp_valid | output | 1 | Decision valid, one cycle after the address phase |
| resp_act | output | 2 | 00 proceed, 01 proceed and forward, 10 retry and forward |
| sp_wr_en | input | 1 | Service-processor state write |
| sp_wr_page | input | 1 | Apply the write to the whole page of `sp_wr_line` |
| sp_wr_line | input | IDX_W | Line index inside the window |
| sp_wr_state | input | 2 | New state: 00 invalid, 01 read-only, 10 read-write |
| fwd_valid | output | 1 | Queue head holds a forwarded request |
| fwd_ready | input | 1 | Service processor takes the head |
| fwd_addr | output | ADDR_W | Line-aligned address of the head request |
| fwd_op | output | 2 | Operation of the head request |

## Verification
The hardest case to reach from the ports is a full queue meeting an access that would otherwise proceed, along with the duplicate filter acting on a partly filled queue. Random traffic rarely fills all four slots while the reads still target permitted lines. Directed steps therefore park the queue full with retries to four distinct invalid lines, then read a read-write line and confirm the forced retry, the unchanged head and the original drain order. The random phase then mixes pops, line and page writes and accesses on a small set of lines, so duplicates and full-queue retries also occur in many different states.

// File: rtl/sc_snoop_pkg.sv
package sc_snoop_pkg;

    typedef enum logic [1:0] {
        LS_INVALID    = 2'b00,
        LS_READ_ONLY  = 2'b01,
        LS_READ_WRITE = 2'b10,
        LS_RESERVED   = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_CASTOUT = 2'b10,
        OP_OTHER   = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        ACT_PROCEED     = 2'b00,
        ACT_PROCEED_FWD = 2'b01,
        ACT_RETRY_FWD   = 2'b10
    } snoop_act_e;

    // Fixed action table: operation x line state.
    function automatic snoop_act_e lookup_action(bus_op_e op, line_state_e st);
        snoop_act_e a;
        case (st)
            LS_READ_ONLY: begin
                a = (op == OP_READ) ? ACT_PROCEED : ACT_RETRY_FWD;
            end
            LS_READ_WRITE: begin
                a = (op == OP_CASTOUT) ? ACT_PROCEED_FWD : ACT_PROCEED;
            end
            default: begin
                a = ACT_RETRY_FWD;
            end
        endcase
        return a;
    endfunction

    function automatic logic act_forwards(snoop_act_e a);
        return (a == ACT_PROCEED_FWD) || (a == ACT_RETRY_FWD);
    endfunction

endpackage

// File: rtl/sc_line_table.sv
module sc_line_table
    import sc_snoop_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int PAGE_LINES = 8,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int PL_W      = (PAGE_LINES > 1) ? $clog2(PAGE_LINES) : 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_page,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [1:0]             wr_state,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [1:0]             rd_state,
    output logic [2*NUM_LINES-1:0] all_states
);

    localparam logic [IDX_W-1:0] PAGE_MASK = ~IDX_W'((1 << PL_W) - 1);

    logic [1:0] st_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic hit_line;
        logic hit_page;

        assign hit_line = (wr_idx == MY_IDX);
        assign hit_page = ((wr_idx & PAGE_MASK) == (MY_IDX & PAGE_MASK));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g] <= LS_INVALID;
            end else if (wr_en && (wr_page ? hit_page : hit_line)) begin
                st_q[g] <= wr_state;
            end
        end

        assign all_states[2*g +: 2] = st_q[g];
    end

    always_comb begin
        rd_state = LS_INVALID;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_state = st_q[i];
            end
        end
    end

endmodule

// File: rtl/sc_fwd_queue.sv
module sc_fwd_queue #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 26,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [1:0]       push_op,
    input  logic             pop,
    input  logic [TAG_W-1:0] query_tag,
    output logic             query_hit,
    output logic             full,
    output logic             head_valid,
    output logic [TAG_W-1:0] head_tag,
    output logic [1:0]       head_op
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [1:0]       op;
    } fwd_entry_t;

    fwd_entry_t       mem_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (mem_q[g].tag == query_tag);
    end

    assign query_hit  = |hit_vec;
    assign full       = &vld_q;
    assign head_valid = vld_q[rd_ptr_q];
    assign head_tag   = mem_q[rd_ptr_q].tag;
    assign head_op    = mem_q[rd_ptr_q].op;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push && !full) begin
                vld_q[wr_ptr_q] <= 1'b1;
                wr_ptr_q        <= ptr_next(wr_ptr_q);
            end
            if (pop && head_valid) begin
                vld_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q        <= ptr_next(rd_ptr_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem_q[wr_ptr_q] <= '{tag: push_tag, op: push_op};
        end
    end

endmodule

// File: rtl/sc_decide.sv
module sc_decide
    import sc_snoop_pkg::*;
#(
    parameter int ADDR_W                = 32,
    parameter int OFF_W                 = 6,
    parameter int NUM_LINES             = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
    localparam int IDX_W                = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic [1:0]        line_state,
    input  logic              q_full,
    input  logic              q_dup,
    output logic              in_win,
    output logic [IDX_W-1:0]  line_idx,
    output logic [1:0]        act,
    output logic              want_push
);

    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NUM_LINES) << OFF_W;

    logic [ADDR_W-1:0] offset;
    snoop_act_e        base_act;

    assign offset   = addr - WIN_BASE;
    assign in_win   = (addr >= WIN_BASE) && (offset < WIN_BYTES);
    assign line_idx = offset[OFF_W +: IDX_W];
    assign base_act = lookup_action(bus_op_e'(op), line_state_e'(line_state));

    always_comb begin
        if (!in_win) begin
            act       = ACT_PROCEED;
            want_push = 1'b0;
        end else if (q_full) begin
            act       = ACT_RETRY_FWD;
            want_push = 1'b0;
        end else begin
            act       = base_act;
            want_push = act_forwards(base_act) && !q_dup;
        end
    end

endmodule

// File: rtl/sc_snoop_gate.sv
module sc_snoop_gate
    import sc_snoop_pkg::*;
#(
    parameter int ADDR_W                  = 32,
    parameter int LINE_BYTES              = 64,
    parameter int PAGE_LINES              = 8,
    parameter int NUM_PAGES               = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
    parameter int FWD_DEPTH               = 4,
    localparam int NUM_LINES              = PAGE_LINES * NUM_PAGES,
    localparam int IDX_W                  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int OFF_W                  = $clog2(LINE_BYTES),
    localparam int TAG_W                  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [1:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_act,
    input  logic              sp_wr_en,
    input  logic              sp_wr_page,
    input  logic [IDX_W-1:0]  sp_wr_line,
    input  logic [1:0]        sp_wr_state,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [1:0]        fwd_op
);

    logic [IDX_W-1:0]       line_idx;
    logic [1:0]             rd_state;
    logic                   in_win;
    logic [1:0]             dec_act;
    logic                   dec_push;
    logic                   q_full;
    logic                   q_dup;
    logic                   q_push;
    logic                   q_pop;
    logic [TAG_W-1:0]       bus_tag;
    logic [TAG_W-1:0]       head_tag;
    logic [2*NUM_LINES-1:0] line_states;

    assign bus_tag = bus_addr[ADDR_W-1:OFF_W];

    sc_line_table #(
        .NUM_LINES (NUM_LINES),
        .PAGE_LINES(PAGE_LINES)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sp_wr_en),
        .wr_page   (sp_wr_page),
        .wr_idx    (sp_wr_line),
        .wr_state  (sp_wr_state),
        .rd_idx    (line_idx),
        .rd_state  (rd_state),
        .all_states(line_states)
    );

    sc_decide #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .NUM_LINES(NUM_LINES),
        .WIN_BASE (WIN_BASE)
    ) u_decide (
        .addr      (bus_addr),
        .op        (bus_op),
        .line_state(rd_state),
        .q_full    (q_full),
        .q_dup     (q_dup),
        .in_win    (in_win),
        .line_idx  (line_idx),
        .act       (dec_act),
        .want_push (dec_push)
    );

    assign q_push = bus_valid && dec_push;
    assign q_pop  = fwd_ready && fwd_valid;

    sc_fwd_queue #(
        .DEPTH(FWD_DEPTH),
        .TAG_W(TAG_W)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_tag  (bus_tag),
        .push_op   (bus_op),
        .pop       (q_pop),
        .query_tag (bus_tag),
        .query_hit (q_dup),
        .full      (q_full),
        .head_valid(fwd_valid),
        .head_tag  (head_tag),
        .head_op   (fwd_op)
    );

    assign fwd_addr = {head_tag, {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_act   <= ACT_PROCEED;
        end else begin
            resp_valid <= bus_valid;
            resp_act   <= bus_valid ? dec_act : ACT_PROCEED;
        end
    end

endmodule

// File: rtl/sc_snoop_gate_chk.sv
module sc_snoop_gate_chk #(
    parameter int ADDR_W                  = 32,
    parameter int OFF_W                   = 6,
    parameter int NUM_LINES               = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_valid,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   resp_valid,
    input logic [1:0]             resp_act,
    input logic                   sp_wr_en,
    input logic                   fwd_valid,
    input logic                   fwd_ready,
    input logic [ADDR_W-1:0]      fwd_addr,
    input logic [1:0]             fwd_op,
    input logic                   q_full,
    input logic                   q_push,
    input logic [2*NUM_LINES-1:0] line_states
);

    localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + (ADDR_W'(NUM_LINES) << OFF_W);

    logic addr_in_win;
    assign addr_in_win = (bus_addr >= WIN_BASE) && (bus_addr < WIN_END);

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid == ($past(bus_valid) && !$past(rst))); // R6

    AST_ACT_ENCODING: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_act != 2'b11)); // R6

    AST_OUTSIDE_PROCEEDS: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !$past(addr_in_win)) |-> (resp_act == 2'b00)); // R1

    AST_NO_PUSH_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        q_push |-> addr_in_win); // R1

    AST_FULL_FORCES_RETRY: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && $past(q_full) && $past(addr_in_win)) |-> (resp_act == 2'b10)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_push)); // R8

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_op))); // R7

    AST_SNOOP_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        !sp_wr_en |=> $stable(line_states)); // R10

endmodule

bind sc_snoop_gate sc_snoop_gate_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .NUM_LINES(NUM_LINES),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .resp_valid (resp_valid),
    .resp_act   (resp_act),
    .sp_wr_en   (sp_wr_en),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .fwd_addr   (fwd_addr),
    .fwd_op     (fwd_op),
    .q_full     (q_full),
    .q_push     (q_push),
    .line_states(line_states)
);

// File: tb/sc_snoop_gate_bench.sv
`timescale 1ns/1ps
module sc_snoop_gate_bench;

    localparam int          NL    = 32;
    localparam int          PL    = 8;
    localparam int          QD    = 4;
    localparam logic [31:0] BASE  = 32'h0001_0000;
    localparam logic [31:0] WEND  = 32'h0001_0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic [1:0]  bus_op = 2'b00;
    logic [31:0] bus_addr = 32'h0;
    logic        resp_valid;
    logic [1:0]  resp_act;
    logic        sp_wr_en = 1'b0;
    logic        sp_wr_page = 1'b0;
    logic [4:0]  sp_wr_line = 5'd0;
    logic [1:0]  sp_wr_state = 2'b00;
    logic        fwd_valid;
    logic        fwd_ready = 1'b0;
    logic [31:0] fwd_addr;
    logic [1:0]  fwd_op;

    always #2.5 clk = ~clk;

    sc_snoop_gate u_sc_snoop_gate (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_op     (bus_op),
        .bus_addr   (bus_addr),
        .resp_valid (resp_valid),
        .resp_act   (resp_act),
        .sp_wr_en   (sp_wr_en),
        .sp_wr_page (sp_wr_page),
        .sp_wr_line (sp_wr_line),
        .sp_wr_state(sp_wr_state),
        .fwd_valid  (fwd_valid),
        .fwd_ready  (fwd_ready),
        .fwd_addr   (fwd_addr),
        .fwd_op     (fwd_op)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [1:0]  m_state [NL];
    logic [31:0] m_qaddr [QD];
    logic [1:0]  m_qop   [QD];
    int          m_qn = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_window(logic [31:0] a);
        return (a >= BASE) && (a < WEND);
    endfunction

    function automatic int line_of(logic [31:0] a);
        return int'((a - BASE) >> 6);
    endfunction

    function automatic logic [1:0] table_act(logic [1:0] op, logic [1:0] st);
        if (st == 2'b01) return (op == 2'b00) ? 2'b00 : 2'b10;
        if (st == 2'b10) return (op == 2'b10) ? 2'b01 : 2'b00;
        return 2'b10;
    endfunction

    function automatic logic [1:0] exp_act(logic [1:0] op, logic [31:0] a);
        if (!in_window(a)) return 2'b00;
        if (m_qn == QD) return 2'b10;
        return table_act(op, m_state[line_of(a)]);
    endfunction

    function automatic string req_of(logic [1:0] op, logic [31:0] a);
        logic [1:0] st;
        if (!in_window(a)) return "R1";
        if (m_qn == QD) return "R8";
        st = m_state[line_of(a)];
        if (st == 2'b00 || st == 2'b11) return "R4";
        if (op == 2'b10) return "R5";
        if (op == 2'b00) return "R2";
        return "R3";
    endfunction

    task automatic check_head(input string req);
        if (m_qn > 0) begin
            chk(fwd_valid === 1'b1, req, {31'd0, fwd_valid}, 32'd1);
            chk(fwd_addr === m_qaddr[0], req, fwd_addr, m_qaddr[0]);
            chk(fwd_op === m_qop[0], req, {30'd0, fwd_op}, {30'd0, m_qop[0]});
        end else begin
            chk(fwd_valid === 1'b0, req, {31'd0, fwd_valid}, 32'd0);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [31:0] a, input string req);
        logic [1:0]  e;
        logic [31:0] la;
        bit          dup;
        e   = exp_act(op, a);
        la  = {a[31:6], 6'd0};
        dup = 1'b0;
        for (int i = 0; i < m_qn; i++) if (m_qaddr[i] == la) dup = 1'b1;
        @(negedge clk);
        bus_valid = 1'b1; bus_op = op; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(resp_valid === 1'b1, "R6", {31'd0, resp_valid}, 32'd1);
        chk(resp_act === e, req, {30'd0, resp_act}, {30'd0, e});
        if (in_window(a) && m_qn < QD && (e == 2'b01 || e == 2'b10) && !dup) begin
            m_qaddr[m_qn] = la;
            m_qop[m_qn]   = op;
            m_qn++;
        end
        check_head("R7");
    endtask

    task automatic idle_check;
        @(negedge clk);
        chk(resp_valid === 1'b0, "R6", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic sp_write(input bit page, input int idx, input logic [1:0] st);
        @(negedge clk);
        sp_wr_en = 1'b1; sp_wr_page = page; sp_wr_line = 5'(idx); sp_wr_state = st;
        @(negedge clk);
        sp_wr_en = 1'b0; sp_wr_page = 1'b0;
        if (page) begin
            for (int i = 0; i < NL; i++) if ((i / PL) == (idx / PL)) m_state[i] = st;
        end else begin
            m_state[idx] = st;
        end
    endtask

    task automatic pop_one(input string req);
        @(negedge clk);
        check_head(req);
        fwd_ready = 1'b1;
        @(negedge clk);
        fwd_ready = 1'b0;
        if (m_qn > 0) begin
            for (int i = 0; i < QD - 1; i++) begin
                m_qaddr[i] = m_qaddr[i + 1];
                m_qop[i]   = m_qop[i + 1];
            end
            m_qn--;
        end
        check_head(req);
    endtask

    function automatic logic [31:0] line_addr(int idx, int off);
        return BASE + 32'(idx * 64 + off);
    endfunction

    initial begin
        repeat (2000 * 100) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9157));
        for (int i = 0; i < NL; i++) m_state[i] = 2'b00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        @(negedge clk);
        chk(resp_valid === 1'b0, "R12", {31'd0, resp_valid}, 32'd0);
        chk(fwd_valid === 1'b0, "R12", {31'd0, fwd_valid}, 32'd0);
        access(2'b00, line_addr(3, 8), "R12");        // invalid after reset -> retry, queued
        idle_check();
        access(2'b00, line_addr(3, 16), "R9");        // same line, retried, not queued twice
        pop_one("R9");                                // one entry only -> empty after

        // R10: repair by service processor
        access(2'b01, line_addr(3, 0), "R10");        // still retried
        sp_write(1'b0, 3, 2'b01);
        access(2'b00, line_addr(3, 4), "R10");        // read-only read proceeds
        access(2'b01, line_addr(3, 4), "R3");         // write to read-only retried
        pop_one("R7");
        pop_one("R7");

        // R11: page write covers lines 8..15 only
        sp_write(1'b1, 9, 2'b10);
        access(2'b00, line_addr(8, 0), "R11");
        access(2'b01, line_addr(15, 63), "R11");
        access(2'b10, line_addr(12, 0), "R5");        // cast-out of read-write
        access(2'b00, line_addr(16, 0), "R11");       // next page untouched
        access(2'b00, line_addr(7, 0), "R11");        // previous page untouched
        access(2'b11, line_addr(10, 0), "R3");        // op 11 as write
        pop_one("R7");
        pop_one("R7");
        pop_one("R7");

        // R1: window edges
        access(2'b01, 32'h0000_FFFF, "R1");
        access(2'b00, WEND, "R1");
        access(2'b10, 32'hFFFF_FFC0, "R1");
        access(2'b00, line_addr(31, 63), "R4");

        // R8: full queue
        pop_one("R7");
        for (int i = 20; i < 24; i++) access(2'b01, line_addr(i, 0), "R4");
        access(2'b00, line_addr(8, 0), "R8");
        access(2'b10, line_addr(12, 0), "R8");
        access(2'b00, 32'h0000_0040, "R1");
        for (int i = 0; i < 4; i++) pop_one("R7");
        access(2'b00, line_addr(8, 0), "R2");

        // R4: reserved state behaves as invalid
        sp_write(1'b0, 5, 2'b11);
        access(2'b00, line_addr(5, 0), "R4");
        pop_one("R7");

        // random phase
        for (int it = 0; it < 1500; it++) begin
            int unsigned k;
            k = $urandom_range(0, 99);
            if (k < 60) begin
                logic [31:0] a;
                logic [1:0]  op;
                op = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 99) < 85)
                    a = line_addr(int'($urandom_range(0, 11)) * 3 % NL, int'($urandom_range(0, 63)));
                else if ($urandom_range(0, 1) == 0)
                    a = $urandom_range(0, 32'h0000_FFFF);
                else
                    a = WEND + $urandom_range(0, 32'h000F_FFFF);
                access(op, a, req_of(op, a));
            end else if (k < 78) begin
                sp_write($urandom_range(0, 7) == 0, int'($urandom_range(0, NL - 1)),
                         2'($urandom_range(0, 2)));
            end else if (k < 95) begin
                if (m_qn > 0) pop_one("R7");
                else idle_check();
            end else begin
                idle_check();
            end
        end
        while (m_qn > 0) pop_one("R7");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule